// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block runs read and write cycles on one external asynchronous memory bus shared by four chip selects, suited to SRAM, NOR flash and NAND-style parts. An internal master presents a request with a byte address, a direction and write data over a valid/ready handshake. The top address bits pick the chip select. The block then drives a three-phase cycle on the bus: setup, strobe and hold. It ends the cycle with a one-cycle completion pulse that returns the read data.

Each chip select carries its own configuration, loaded through a small write port. This covers separate setup/strobe/hold counts for reads and for writes, an 8-bit or 16-bit data width, a mode in which the select line is only active during the strobe, a mode in which a device wait line stretches the strobe, and a turnaround count. The turnaround count puts idle cycles between accesses when the chip select or the direction changes.

Top module: `async_mem_sequencer`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. After acceptance `req_ready` stays low until the cycle after the last hold cycle. In that cycle `done` is high for one clock and `req_ready` is high again.
- R2: An accepted access runs setup cycles, then strobe cycles, then hold cycles, using the read or write counts of its chip select. `mem_oe_n` is low only during the strobe of a read. `mem_we_n` is low only during the strobe of a write. All select and strobe outputs are active low.
- R3: A setup, strobe or hold count of zero gives one cycle of that phase.
- R4: `req_addr[27:26]` selects the chip select. The device address is `req_addr[25:0]` on an 8-bit chip select and `{1'b0, req_addr[25:1]}` on a 16-bit one. It stays stable for the whole access.
- R5: Mode word bit 0 set gives a 16-bit chip select, which returns `mem_din` in full. Clear, which is the reset value, gives an 8-bit chip select, which returns `{8'h00, mem_din[7:0]}`.
- R6: Mode word bit 1 set enables strobe-only select, where the chip select is low only during the strobe phase. When bit 1 is clear, the chip select is low through setup, strobe and hold. At most one chip select is low at any time.
- R7: Mode word bit 2 set enables extended wait. `mem_wait` passes through two flops. The strobe is held past its programmed last cycle for as long as the synchronised wait is high, and then the normal hold follows.
- R8: Turnaround cycles are inserted after acceptance, with all selects and strobes inactive, when the previous access used another chip select or the other direction. Their number is mode word bits [10:8] of the previous access's chip select.
- R9: No turnaround cycles are inserted between two reads or two writes to the same chip select.
- R10: Read data is `mem_din` as sampled on the last strobe cycle, including any wait extension. It is valid on `rd_data` while `done` is high.
- R11: During a write, `mem_dout_en` is high and `mem_dout` holds the write data from the first setup cycle through the last hold cycle. `mem_dout_en` is low at all other times.
- R12: A config write with `cfg_we` high writes to chip select `cfg_target`. Selector 0 writes the read counts and selector 1 writes the write counts, with setup in bits [5:0], strobe in [13:8] and hold in [18:16]. Selector 2 writes the mode word. Selector 3 changes nothing. An access uses the configuration that was in place at its acceptance edge.
- R13: After reset all chip selects and strobes are high, `mem_dout_en`, `done` and `rd_data` are zero, `req_ready` is high, and all configuration fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 2 | Chip select being configured |
| cfg_sel | input | 2 | Word selector: 0 read counts, 1 write counts, 2 mode |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Byte address; top two bits select the chip select |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data of the last read |
| mem_cs_n | output | 4 | Chip selects, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | 26 | Device address |
| mem_dout | output | 16 | Write data to the bus |
| mem_dout_en | output | 1 | Drive enable for the data bus |
| mem_din | input | 16 | Data from the bus |
| mem_wait | input | 1 | Device wait request, asynchronous |

## Verification
On every cycle, the assertions check bus hygiene: at most one select active, never both strobes, no strobe without a select, no read strobe while the data bus is driven, and the write strobe only with the bus driven. They also check that address and write data hold still through an access, that `done` is a single pulse that comes with `req_ready`, and that acceptance makes the block busy. Phase lengths need the bench's scenarios and its cycle model, because they depend on the stored configuration. These cover zero counts, the separate read and write timing, turnaround being inserted or skipped, the wait stretch through the synchroniser, the exact capture cycle of read data, the narrow and wide returns, and configuration written at the acceptance edge.

// File: rtl/asq_pkg.sv
package asq_pkg;
  localparam int SETUP_W  = 6;
  localparam int STROBE_W = 6;
  localparam int HOLD_W   = 3;
  localparam int TURN_W   = 3;
  localparam int CFG_W    = 32;
  localparam int CNT_W    = 6;

  localparam logic [1:0] SEL_RD   = 2'd0;
  localparam logic [1:0] SEL_WR   = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0]  setup;
    logic [STROBE_W-1:0] strobe;
    logic [HOLD_W-1:0]   hold;
  } times_t;

  typedef struct packed {
    times_t              rd;
    times_t              wr;
    logic                wide;
    logic                sel_strobe;
    logic                ext_wait;
    logic [TURN_W-1:0]   turn;
  } cs_cfg_t;

  function automatic times_t unpack_times(input logic [CFG_W-1:0] w);
    times_t t;
    t.setup  = w[0 +: SETUP_W];
    t.strobe = w[8 +: STROBE_W];
    t.hold   = w[16 +: HOLD_W];
    return t;
  endfunction
endpackage

// File: rtl/asq_cfg_bank.sv
module asq_cfg_bank
  import asq_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [CS_W-1:0]  target_i,
  input  logic [1:0]       sel_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cs_cfg_t          cfg_o [NUM_CS]
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    cs_cfg_t slot_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (we_i && (target_i == CS_W'(g))) begin
        case (sel_i)
          SEL_RD:   slot_q.rd <= unpack_times(wdata_i);
          SEL_WR:   slot_q.wr <= unpack_times(wdata_i);
          SEL_MODE: begin
            slot_q.wide       <= wdata_i[0];
            slot_q.sel_strobe <= wdata_i[1];
            slot_q.ext_wait   <= wdata_i[2];
            slot_q.turn       <= wdata_i[8 +: TURN_W];
          end
          default: ;
        endcase
      end
    end

    assign cfg_o[g] = slot_q;
  end
endmodule

// File: rtl/asq_wait_sync.sv
module asq_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/asq_phase_fsm.sv
module asq_phase_fsm
  import asq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [TURN_W-1:0] turn_len_i,
  input  times_t            times_i,
  input  logic              ext_i,
  input  logic              wait_i,
  output phase_e            phase_o,
  output logic              done_o,
  output logic              capture_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  times_t           times_q;
  logic             ext_q;
  logic             done_q;
  logic             cnt_last;
  logic             stretch;

  // a programmed zero still yields one cycle
  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign cnt_last = (cnt_q == CNT_W'(1));
  assign stretch  = ext_q && wait_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      times_q <= '0;
      ext_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            times_q <= times_i;
            ext_q   <= ext_i;
            if (turn_len_i != '0) begin
              phase_q <= PH_TURN;
              cnt_q   <= CNT_W'(turn_len_i);
            end else begin
              phase_q <= PH_SETUP;
              cnt_q   <= span(CNT_W'(times_i.setup));
            end
          end
        end
        PH_TURN: begin
          if (cnt_last) begin
            phase_q <= PH_SETUP;
            cnt_q   <= span(CNT_W'(times_q.setup));
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_SETUP: begin
          if (cnt_last) begin
            phase_q <= PH_STROBE;
            cnt_q   <= span(CNT_W'(times_q.strobe));
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt_last) begin
            if (!stretch) begin
              phase_q <= PH_HOLD;
              cnt_q   <= span(CNT_W'(times_q.hold));
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_last) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign done_o    = done_q;
  assign capture_o = (phase_q == PH_STROBE) && cnt_last && !stretch;
endmodule

// File: rtl/async_mem_sequencer.sv
module async_mem_sequencer
  import asq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 16,
  localparam int CS_W     = $clog2(NUM_CS),
  localparam int WIN_W    = ADDR_W - CS_W,
  localparam int NARROW_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CS_W-1:0]   cfg_target,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [WIN_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  input  logic              mem_wait
);
  cs_cfg_t           cfg_tbl [NUM_CS];
  cs_cfg_t           new_cfg;
  times_t            new_times;
  logic [CS_W-1:0]   req_cs;
  logic              accept;
  logic              need_turn;
  logic [TURN_W-1:0] turn_len;
  logic              wait_s;
  phase_e            phase;
  logic              capture;

  // state of the access in progress (or the last one, while idle)
  logic              op_valid_q;
  logic [CS_W-1:0]   cs_q;
  logic              wr_q;
  logic              sel_q;
  logic              wide_q;
  logic [TURN_W-1:0] turn_q;
  logic [WIN_W-1:0]  addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;

  logic in_access;
  logic strobing;
  logic cs_active;

  asq_cfg_bank #(.NUM_CS(NUM_CS)) i_cfg_bank (
    .clk      (clk),
    .rst      (rst),
    .we_i     (cfg_we),
    .target_i (cfg_target),
    .sel_i    (cfg_sel),
    .wdata_i  (cfg_wdata),
    .cfg_o    (cfg_tbl)
  );

  asq_wait_sync #(.STAGES(2)) i_wait_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (mem_wait),
    .sync_o  (wait_s)
  );

  assign req_cs    = req_addr[ADDR_W-1 -: CS_W];
  assign new_cfg   = cfg_tbl[req_cs];
  assign new_times = req_write ? new_cfg.wr : new_cfg.rd;
  assign accept    = req_valid && req_ready;
  assign need_turn = op_valid_q && ((cs_q != req_cs) || (wr_q != req_write));
  assign turn_len  = need_turn ? turn_q : '0;

  asq_phase_fsm i_phase_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (accept),
    .turn_len_i (turn_len),
    .times_i    (new_times),
    .ext_i      (new_cfg.ext_wait),
    .wait_i     (wait_s),
    .phase_o    (phase),
    .done_o     (done),
    .capture_o  (capture)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid_q <= 1'b0;
      cs_q       <= '0;
      wr_q       <= 1'b0;
      sel_q      <= 1'b0;
      wide_q     <= 1'b0;
      turn_q     <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else if (accept) begin
      op_valid_q <= 1'b1;
      cs_q       <= req_cs;
      wr_q       <= req_write;
      sel_q      <= new_cfg.sel_strobe;
      wide_q     <= new_cfg.wide;
      turn_q     <= new_cfg.turn;
      addr_q     <= new_cfg.wide ? {1'b0, req_addr[WIN_W-1:1]} : req_addr[WIN_W-1:0];
      wdata_q    <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (capture && !wr_q) begin
      rd_q <= wide_q ? mem_din : {{(DATA_W-NARROW_W){1'b0}}, mem_din[NARROW_W-1:0]};
    end
  end

  assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobing  = (phase == PH_STROBE);
  assign cs_active = strobing || (!sel_q && in_access);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign mem_cs_n[g] = !(cs_active && (cs_q == CS_W'(g)));
  end

  assign req_ready   = (phase == PH_IDLE);
  assign mem_oe_n    = !(strobing && !wr_q);
  assign mem_we_n    = !(strobing && wr_q);
  assign mem_dout_en = in_access && wr_q;
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign rd_data     = rd_q;
endmodule

// File: rtl/asq_checker.sv
module asq_checker #(
  parameter int NUM_CS = 4,
  parameter int WIN_W  = 26,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dout_en,
  input logic [WIN_W-1:0]  mem_addr,
  input logic [DATA_W-1:0] mem_dout
);
  p_one_select_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  p_strobe_has_select_r6: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> ($countones(~mem_cs_n) == 1));

  p_no_read_while_driving_r11: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dout_en);

  p_write_strobe_driven_r11: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dout_en);

  p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_with_ready_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  p_wdata_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_dout));
endmodule

bind async_mem_sequencer asq_checker #(
  .NUM_CS (NUM_CS),
  .WIN_W  (WIN_W),
  .DATA_W (DATA_W)
) i_asq_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .mem_cs_n    (mem_cs_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_dout_en (mem_dout_en),
  .mem_addr    (mem_addr),
  .mem_dout    (mem_dout)
);

// File: tb/test_async_mem_sequencer.sv
module test_async_mem_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_target = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [15:0] rd_data;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n;
  logic [25:0] mem_addr;
  logic [15:0] mem_dout;
  logic        mem_dout_en;
  logic [15:0] mem_din = '0;
  logic        mem_wait = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_mem_sequencer i_async_mem_sequencer (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state: kinds 0 idle, 1 turn, 2 setup, 3 strobe, 4 last strobe, 5 hold
  int          m_cur = 0;
  bit          m_done = 0;
  int          q[$];
  bit          m_w1 = 0, m_w2 = 0, m_prev_v = 0;
  int          m_cs = 0, m_turn = 0;
  bit          m_wr = 0, m_sel = 0, m_ext = 0, m_wide = 0;
  logic [27:0] m_addr = '0;
  logic [15:0] m_wdata = '0, m_rd = '0;
  int cf_rs[4], cf_rt[4], cf_rh[4], cf_ws[4], cf_wt[4], cf_wh[4], cf_turn[4];
  bit cf_wide[4], cf_sel[4], cf_ext[4];

  function automatic int one_min(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit nxt_done;
    if (rst) begin
      m_cur = 0; m_done = 0; q.delete(); m_w1 = 0; m_w2 = 0; m_prev_v = 0;
      m_rd = '0; m_addr = '0; m_wdata = '0;
      for (int i = 0; i < 4; i++) begin
        cf_rs[i] = 0; cf_rt[i] = 0; cf_rh[i] = 0; cf_ws[i] = 0; cf_wt[i] = 0; cf_wh[i] = 0;
        cf_turn[i] = 0; cf_wide[i] = 0; cf_sel[i] = 0; cf_ext[i] = 0;
      end
      return;
    end
    nxt_done = 0;
    if (m_cur == 0) begin
      if (req_valid) begin
        int c, s, t, h, ta;
        c  = int'(req_addr[27:26]);
        ta = (m_prev_v && (m_cs != c || m_wr != req_write)) ? m_turn : 0;
        s  = one_min(req_write ? cf_ws[c] : cf_rs[c]);
        t  = one_min(req_write ? cf_wt[c] : cf_rt[c]);
        h  = one_min(req_write ? cf_wh[c] : cf_rh[c]);
        m_cs = c; m_wr = req_write; m_sel = cf_sel[c]; m_ext = cf_ext[c];
        m_wide = cf_wide[c]; m_turn = cf_turn[c]; m_addr = req_addr; m_wdata = req_wdata;
        m_prev_v = 1;
        for (int i = 0; i < ta; i++) q.push_back(1);
        for (int i = 0; i < s; i++) q.push_back(2);
        for (int i = 0; i < t - 1; i++) q.push_back(3);
        q.push_back(4);
        for (int i = 0; i < h; i++) q.push_back(5);
        m_cur = q.pop_front();
      end
    end else if (m_cur == 4 && m_ext && m_w2) begin
      m_cur = 4;
    end else begin
      if (m_cur == 4 && !m_wr) m_rd = m_wide ? mem_din : {8'h00, mem_din[7:0]};
      if (q.size() == 0) begin
        m_cur = 0;
        nxt_done = 1;
      end else begin
        m_cur = q.pop_front();
      end
    end
    m_done = nxt_done;
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: begin cf_rs[cfg_target] = int'(cfg_wdata[5:0]); cf_rt[cfg_target] = int'(cfg_wdata[13:8]); cf_rh[cfg_target] = int'(cfg_wdata[18:16]); end
        2'd1: begin cf_ws[cfg_target] = int'(cfg_wdata[5:0]); cf_wt[cfg_target] = int'(cfg_wdata[13:8]); cf_wh[cfg_target] = int'(cfg_wdata[18:16]); end
        2'd2: begin cf_wide[cfg_target] = cfg_wdata[0]; cf_sel[cfg_target] = cfg_wdata[1];
                    cf_ext[cfg_target] = cfg_wdata[2]; cf_turn[cfg_target] = int'(cfg_wdata[10:8]); end
        default: ;
      endcase
    end
    m_w2 = m_w1;
    m_w1 = mem_wait;
  endtask

  task automatic compare();
    logic [3:0]  exp_cs;
    logic [25:0] exp_addr;
    bit act, strb;
    act  = (m_cur >= 2);
    strb = (m_cur == 3 || m_cur == 4);
    exp_cs = 4'hF;
    if (act && (strb || !m_sel)) exp_cs[m_cs] = 1'b0;
    exp_addr = m_wide ? {1'b0, m_addr[25:1]} : m_addr[25:0];
    check("R6 select lines", 32'(mem_cs_n), 32'(exp_cs));
    check("R2 read strobe", 32'(mem_oe_n), 32'(!(strb && !m_wr)));
    check("R2 write strobe", 32'(mem_we_n), 32'(!(strb && m_wr)));
    check("R11 drive enable", 32'(mem_dout_en), 32'(act && m_wr));
    check("R1 ready", 32'(req_ready), 32'(m_cur == 0));
    check("R1 done", 32'(done), 32'(m_done));
    if (act) check("R4 device address", 32'(mem_addr), 32'(exp_addr));
    if (act && m_wr) check("R11 write data", 32'(mem_dout), 32'(m_wdata));
    if (m_done && !m_wr) check("R10 read data", 32'(rd_data), 32'(m_rd));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic set_cfg(int tgt, int sel, logic [31:0] w);
    cfg_we = 1'b1; cfg_target = 2'(tgt); cfg_sel = 2'(sel); cfg_wdata = w;
    tick();
    cfg_we = 1'b0;
  endtask

  // issue one access, return after the done cycle; latency = index of the done cycle
  task automatic do_access(bit wr, logic [27:0] a, logic [15:0] wd, int waitn,
                           int exp_lat, string tag);
    int lat;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    tick();
    req_valid = 1'b0; cfg_we = 1'b0;
    lat = 0;
    while (!done && lat < 400) begin
      mem_wait = (lat < waitn);
      mem_din  = 16'hA5C0 ^ 16'(lat);
      tick();
      lat++;
    end
    mem_wait = 1'b0;
    check(tag, 32'(lat), 32'(exp_lat));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R13 reset state
    check("R13 ready after reset", 32'(req_ready), 32'd1);
    check("R13 selects after reset", 32'(mem_cs_n), 32'hF);
    check("R13 strobes after reset", 32'({mem_oe_n, mem_we_n}), 32'h3);
    check("R13 outputs after reset", 32'({done, mem_dout_en, rd_data}), 32'd0);

    // R3 R5: default zero config, 8-bit read, one cycle per phase
    do_access(1'b0, 28'h0000124, 16'h0, 0, 3, "R3 zero counts latency");
    check("R5 narrow read zero-extends", 32'(rd_data), 32'h00C1);

    set_cfg(1, 0, 32'h0002_0403);
    set_cfg(1, 1, 32'h0001_0502);
    set_cfg(1, 2, 32'h0000_0201);
    set_cfg(2, 1, 32'h0001_0201);
    set_cfg(2, 2, 32'h0000_0002);
    set_cfg(3, 0, 32'h0001_0202);
    set_cfg(3, 2, 32'h0000_0004);

    do_access(1'b0, 28'h4001236, 16'h0, 0, 9, "R2 read timing cs1");
    check("R10 wide read captured on last strobe", 32'(rd_data), 32'hA5C6);
    do_access(1'b0, 28'h4001238, 16'h0, 0, 9, "R9 read after read same cs");
    do_access(1'b1, 28'h400123A, 16'hBEEF, 0, 10, "R8 direction change turnaround");
    do_access(1'b1, 28'h400123C, 16'h1234, 0, 8, "R9 write after write same cs");
    do_access(1'b1, 28'h8000040, 16'h5A5A, 0, 6, "R6 strobe-only select write cs2");
    do_access(1'b0, 28'hC0000A1, 16'h0, 8, 12, "R7 wait stretches strobe");
    check("R10 stretched read data", 32'(rd_data), 32'h00CA);
    do_access(1'b0, 28'hC0000A2, 16'h0, 0, 5, "R7 no wait no stretch");

    set_cfg(1, 3, 32'h00FF_FFFF);
    do_access(1'b0, 28'h4000010, 16'h0, 0, 9, "R12 selector 3 ignored");

    cfg_we = 1'b1; cfg_target = 2'd0; cfg_sel = 2'd0; cfg_wdata = 32'h0003_0303;
    do_access(1'b0, 28'h0000200, 16'h0, 0, 5, "R12 config at accept edge not used");
    do_access(1'b0, 28'h0000202, 16'h0, 0, 9, "R12 new config on next access");

    repeat (3) tick();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule